// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold and Trailing-Data Interrupts

This block holds the transmit and receive byte queues that sit between a serial bus engine and its register interface. Software writes outgoing bytes into a transmit data port and reads incoming bytes from a receive data port. The bus engine pops transmit bytes when it is ready to shift them out, and pushes received bytes as they arrive. Each queue has an enable, a trigger level and a level readout. Misuse of either side of a queue raises a sticky error flag.

Interrupt sources collect in a pending register that is cleared by writing ones. The threshold sources fire while the transmit queue has drained to its trigger level or the receive queue has filled to its trigger level. A trailing source fires when a partly filled receive queue, holding fewer bytes than its trigger, has had no activity for a programmed number of bus idle periods. This lets software collect the tail of a message that will never reach the trigger. A single interrupt line is the OR of the pending sources that have an enable.

Register word addresses on `reg_addr`: 0 queue control, 1 trailing limit, 2 interrupt enable, 3 interrupt pending, 4 queue status, 5 transmit data (write), 6 receive data (read).

Top module: `tfq_fifo_pair`

## Requirements
- R1: After reset the control, trailing limit, enable and pending registers read 0. Control (address 0) holds the receive enable at bit 0, the transmit enable at bit 1, the receive trigger in bits [10:4] and the transmit trigger in bits [22:16], and it reads back as written.
- R2: Bytes written to address 5 while transmit is enabled leave on `bus_tx_data` in write order, and each `bus_tx_pop` advances to the next byte.
- R3: Bytes pushed with `bus_rx_push` while receive is enabled read back from address 6 in arrival order, and each such read removes one byte. A read of an empty receive queue returns 0.
- R4: Status (address 4) gives the transmit level in [6:0], transmit full at bit 7, transmit empty at bit 8, the receive level in [22:16], receive full at bit 23 and receive empty at bit 24.
- R5: A queue whose enable is 0 is emptied and ignores pushes and pops on both sides without raising any pending bit.
- R6: Pending bit 0 is set whenever transmit is enabled and its level is at or below the transmit trigger. Pending bit 1 is set whenever receive is enabled and its level is at or at or above the receive trigger. While its condition holds, a bit that is cleared sets again.
- R7: Pending bit 2 records a bus pop of an empty transmit queue, bit 3 a write to a full transmit queue, bit 4 a read of an empty receive queue, and bit 5 a bus push into a full receive queue. These bits stay set until cleared.
- R8: A push into a full queue is dropped, and the level never exceeds the depth.
- R9: Pending bit 6 is set on the Nth `bit_tick` counted while the receive queue is enabled, non-empty and below its trigger, where N is the trailing limit at address 1 in bits [3:0] (0 acts as 1). Any receive push or read restarts the count, and the bit fires once per idle stretch.
- R10: A write to address 3 clears exactly the pending bits written as 1.
- R11: A pulse on `xfer_event` sets pending bit 9.
- R12: `irq` is high exactly when some pending bit is also enabled at address 2. Only bits 0, 1, 6 and 9 of the enable register are writable, and the others read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 6) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| bus_tx_pop | input | 1 | Bus engine takes the transmit head byte |
| bus_tx_data | output | 8 | Transmit head byte (0 when empty) |
| bus_rx_push | input | 1 | Bus engine delivers a received byte |
| bus_rx_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per bus idle period |
| xfer_event | input | 1 | Transfer status event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block at its default depth of 16 entries. This keeps both queues small enough that a random mix of writes, pops, pushes and reads fills them and overruns them within a few hundred cycles. The directed part drives each queue exactly to full and past empty. It also programs a trailing limit of 3 with a receive trigger of 4, which puts the exact tick on which the trailing bit fires within reach.

// File: rtl/tfq_pkg.sv
package tfq_pkg;

    localparam int RA_W = 3;

    localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
    localparam logic [RA_W-1:0] RA_TRAIL = 3'd1;
    localparam logic [RA_W-1:0] RA_IEN   = 3'd2;
    localparam logic [RA_W-1:0] RA_PEND  = 3'd3;
    localparam logic [RA_W-1:0] RA_FSTAT = 3'd4;
    localparam logic [RA_W-1:0] RA_TXD   = 3'd5;
    localparam logic [RA_W-1:0] RA_RXD   = 3'd6;

    localparam int PB_TX_LOW   = 0;
    localparam int PB_RX_HIGH  = 1;
    localparam int PB_TX_UDF   = 2;
    localparam int PB_TX_OVF   = 3;
    localparam int PB_RX_UDF   = 4;
    localparam int PB_RX_OVF   = 5;
    localparam int PB_TRAIL    = 6;
    localparam int PB_XFER     = 9;

    localparam int PEND_W = 10;
    localparam int TRIG_W = 7;
    localparam int LIM_W  = 4;

    localparam logic [PEND_W-1:0] PEND_IMPL = 10'b10_0111_1111;
    localparam logic [PEND_W-1:0] IEN_IMPL  = 10'b10_0100_0011;

    typedef struct packed {
        logic              rx_en;
        logic              tx_en;
        logic [TRIG_W-1:0] rx_trig;
        logic [TRIG_W-1:0] tx_trig;
        logic [LIM_W-1:0]  trail_lim;
        logic [PEND_W-1:0] ien;
        logic [PEND_W-1:0] pend;
    } ctl_state_t;

endpackage

// File: rtl/tfq_byte_fifo.sv
module tfq_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             push_err,
    output logic             pop_err
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rd;
        logic [LVL_W-1:0] lvl;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [7:0]  mem_q [DEPTH];
    logic        do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full     = (st_q.lvl == LVL_W'(DEPTH));
    assign empty    = (st_q.lvl == '0);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && !empty && !flush;
    assign push_err = push && full;
    assign pop_err  = pop && empty;
    assign level    = st_q.lvl;
    assign head     = empty ? 8'h00 : mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = step(st_q.wr);
            if (do_pop)  st_d.rd = step(st_q.rd);
            if (do_push && !do_pop)      st_d.lvl = st_q.lvl + LVL_W'(1);
            else if (!do_push && do_pop) st_d.lvl = st_q.lvl - LVL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

endmodule

// File: rtl/tfq_trail_timer.sv
module tfq_trail_timer #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             activity,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             fire
);

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
    } trail_state_t;

    trail_state_t     st_d, st_q;
    logic [LIM_W-1:0] goal;
    logic [LIM_W:0]   cnt_inc;

    assign goal    = (limit == '0) ? LIM_W'(1) : limit;
    assign cnt_inc = {1'b0, st_q.cnt} + (LIM_W + 1)'(1);
    assign fire    = arm && !activity && tick && (cnt_inc == {1'b0, goal});

    always_comb begin
        st_d = st_q;
        if (!arm || activity) begin
            st_d.cnt = '0;
        end else if (tick && st_q.cnt != goal) begin
            st_d.cnt = cnt_inc[LIM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tfq_fifo_pair.sv
module tfq_fifo_pair
    import tfq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bus_tx_pop,
    output logic [7:0]  bus_tx_data,
    input  logic        bus_rx_push,
    input  logic [7:0]  bus_rx_data,
    input  logic        bit_tick,
    input  logic        xfer_event,
    output logic        irq
);

    ctl_state_t st_d, st_q;

    logic             tx_push, tx_pop, rx_push, rx_pop;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_perr, tx_uerr, rx_perr, rx_uerr;
    logic [7:0]       rx_head;
    logic [TRIG_W-1:0] tx_lvl7, rx_lvl7;
    logic             trail_arm, trail_fire;
    logic [PEND_W-1:0] pend_set, pend_clr;
    logic             tx_en_w, rx_en_w;
    logic [PEND_W-1:0] pend_w, ien_w;

    assign tx_en_w = st_q.tx_en;
    assign rx_en_w = st_q.rx_en;
    assign pend_w  = st_q.pend;
    assign ien_w   = st_q.ien;

    assign tx_push = reg_wr && (reg_addr == RA_TXD) && st_q.tx_en;
    assign tx_pop  = bus_tx_pop && st_q.tx_en;
    assign rx_push = bus_rx_push && st_q.rx_en;
    assign rx_pop  = reg_rd && (reg_addr == RA_RXD) && st_q.rx_en;

    tfq_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .flush(!st_q.tx_en),
        .push(tx_push), .push_data(reg_wdata[7:0]), .pop(tx_pop),
        .head(bus_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .push_err(tx_perr), .pop_err(tx_uerr)
    );

    tfq_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .flush(!st_q.rx_en),
        .push(rx_push), .push_data(bus_rx_data), .pop(rx_pop),
        .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .push_err(rx_perr), .pop_err(rx_uerr)
    );

    assign tx_lvl7   = TRIG_W'(tx_lvl);
    assign rx_lvl7   = TRIG_W'(rx_lvl);
    assign trail_arm = st_q.rx_en && !rx_empty && (rx_lvl7 < st_q.rx_trig);

    tfq_trail_timer #(.LIM_W(LIM_W)) u_trail (
        .clk(clk), .rst_n(rst_n), .arm(trail_arm),
        .activity(rx_push || rx_pop), .tick(bit_tick),
        .limit(st_q.trail_lim), .fire(trail_fire)
    );

    always_comb begin
        pend_set             = '0;
        pend_set[PB_TX_LOW]  = st_q.tx_en && (tx_lvl7 <= st_q.tx_trig);
        pend_set[PB_RX_HIGH] = st_q.rx_en && (rx_lvl7 >= st_q.rx_trig);
        pend_set[PB_TX_UDF]  = tx_uerr;
        pend_set[PB_TX_OVF]  = tx_perr;
        pend_set[PB_RX_UDF]  = rx_uerr;
        pend_set[PB_RX_OVF]  = rx_perr;
        pend_set[PB_TRAIL]   = trail_fire;
        pend_set[PB_XFER]    = xfer_event;
        pend_clr = (reg_wr && reg_addr == RA_PEND) ? reg_wdata[PEND_W-1:0] : '0;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    st_d.rx_en   = reg_wdata[0];
                    st_d.tx_en   = reg_wdata[1];
                    st_d.rx_trig = reg_wdata[4 +: TRIG_W];
                    st_d.tx_trig = reg_wdata[16 +: TRIG_W];
                end
                RA_TRAIL: st_d.trail_lim = reg_wdata[LIM_W-1:0];
                RA_IEN:   st_d.ien       = reg_wdata[PEND_W-1:0] & IEN_IMPL;
                default: ;
            endcase
        end
        st_d.pend = ((st_q.pend & ~pend_clr) | pend_set) & PEND_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[0]            = st_q.rx_en;
                reg_rdata[1]            = st_q.tx_en;
                reg_rdata[4 +: TRIG_W]  = st_q.rx_trig;
                reg_rdata[16 +: TRIG_W] = st_q.tx_trig;
            end
            RA_TRAIL: reg_rdata[LIM_W-1:0]  = st_q.trail_lim;
            RA_IEN:   reg_rdata[PEND_W-1:0] = st_q.ien;
            RA_PEND:  reg_rdata[PEND_W-1:0] = st_q.pend;
            RA_FSTAT: reg_rdata = {7'b0, rx_empty, rx_full, rx_lvl7,
                                   7'b0, tx_empty, tx_full, tx_lvl7};
            RA_RXD:   reg_rdata[7:0] = rx_head;
            default: ;
        endcase
    end

    assign irq = |(st_q.pend & st_q.ien);

endmodule

// File: rtl/tfq_checker.sv
module tfq_checker #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic             irq,
    input logic             tx_en,
    input logic             rx_en,
    input logic [LVL_W-1:0] tx_lvl,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [9:0]       pend,
    input logic [9:0]       ien
);

    a_r8_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl <= LVL_W'(DEPTH));

    a_r8_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl <= LVL_W'(DEPTH));

    a_r2_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, tx_lvl} <= {1'b0, $past(tx_lvl)} + (LVL_W + 1)'(1)));

    a_r7_tx_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd5 && tx_en && tx_lvl == LVL_W'(DEPTH)) |=> pend[3]);

    a_r7_rx_udf: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd6 && rx_en && rx_lvl == '0) |=> pend[4]);

    a_r5_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (tx_lvl == '0));

    a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (rx_lvl == '0));

    a_r9_trail_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[6]) |-> $past(rx_en && rx_lvl != '0));

    a_r12_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != '0));

    a_r12_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);

endmodule

bind tfq_fifo_pair tfq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .irq(irq), .tx_en(tx_en_w), .rx_en(rx_en_w),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .pend(pend_w), .ien(ien_w)
);

// File: tb/tb_tfq_fifo_pair.sv
module tb_tfq_fifo_pair;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_tx_pop = 1'b0;
    logic [7:0]  bus_tx_data;
    logic        bus_rx_push = 1'b0;
    logic [7:0]  bus_rx_data = '0;
    logic        bit_tick = 1'b0;
    logic        xfer_event = 1'b0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tfq_fifo_pair #(.DEPTH(DEPTH)) dut (.*);

    function automatic logic [31:0] fstat(input int t, input int r);
        logic [31:0] v = '0;
        v[6:0]   = 7'(t);
        v[7]     = (t == DEPTH);
        v[8]     = (t == 0);
        v[22:16] = 7'(r);
        v[23]    = (r == DEPTH);
        v[24]    = (r == 0);
        return v;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit rxe, input bit txe, input int rt, input int tt);
        logic [31:0] v = '0;
        v[0] = rxe; v[1] = txe; v[10:4] = 7'(rt); v[22:16] = 7'(tt);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] d);
        bus_tx_pop = 1'b1;
        #1 d = bus_tx_data;
        @(negedge clk);
        bus_tx_pop = 1'b0;
    endtask

    task automatic rx_give(input logic [7:0] d);
        bus_rx_push = 1'b1; bus_rx_data = d;
        @(negedge clk);
        bus_rx_push = 1'b0;
    endtask

    task automatic tick_once();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        idle(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        logic [7:0]  txq[$];
        logic [7:0]  rxq[$];
        bit e_txu, e_txo, e_rxu, e_rxo;
        void'($urandom(32'd1357));

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 / R4: reset state
        rd(3'd4, v); chk("R4 reset status", v, fstat(0, 0));
        rd(3'd0, v); chk("R1 reset control", v, 32'h0);
        rd(3'd3, v); chk("R1 reset pending", v, 32'h0);
        chk("R12 reset irq", {31'b0, irq}, 32'h0);

        // R1: control readback
        wr(3'd0, ctrl_word(1, 1, 4, 2));
        rd(3'd0, v); chk("R1 control readback", v, ctrl_word(1, 1, 4, 2));

        // R6: tx almost-empty re-sets while condition holds
        idle(2);
        wr(3'd3, 32'h3FF);
        idle(1);
        rd(3'd3, v); chk("R6 tx low re-set", {31'b0, v[0]}, 32'h1);

        // R2 fill tx with 3 bytes, above trigger 2
        wr(3'd5, 32'hA1); wr(3'd5, 32'hB2); wr(3'd5, 32'hC3);
        idle(2);
        wr(3'd3, 32'h3FF);
        idle(1);
        rd(3'd3, v); chk("R6 tx low clears above trigger", {31'b0, v[0]}, 32'h0);
        rd(3'd4, v); chk("R4 tx level 3", v, fstat(3, 0));

        // R6 rx almost-full with 4 bytes
        rx_give(8'h11); rx_give(8'h22); rx_give(8'h33);
        idle(2);
        rd(3'd3, v); chk("R6 rx high below trigger", {31'b0, v[1]}, 32'h0);
        rx_give(8'h44);
        idle(2);
        rd(3'd3, v); chk("R6 rx high at trigger", {31'b0, v[1]}, 32'h1);

        // R3 drain rx in order then underrun
        rd(3'd6, v); chk("R3 rx byte0", v, 32'h11);
        rd(3'd6, v); chk("R3 rx byte1", v, 32'h22);
        rd(3'd6, v); chk("R3 rx byte2", v, 32'h33);
        rd(3'd6, v); chk("R3 rx byte3", v, 32'h44);
        rd(3'd6, v); chk("R3 rx empty read", v, 32'h0);
        rd(3'd3, v); chk("R7 rx underrun", {31'b0, v[4]}, 32'h1);

        // R2 tx order then underrun
        tx_take(b); chk("R2 tx byte0", {24'b0, b}, 32'hA1);
        tx_take(b); chk("R2 tx byte1", {24'b0, b}, 32'hB2);
        tx_take(b); chk("R2 tx byte2", {24'b0, b}, 32'hC3);
        tx_take(b);
        rd(3'd3, v); chk("R7 tx underrun", {31'b0, v[2]}, 32'h1);

        // R8 / R7 overrun on both sides
        for (int i = 0; i < DEPTH + 1; i++) wr(3'd5, 32'(i));
        for (int i = 0; i < DEPTH + 1; i++) rx_give(8'(i + 64));
        rd(3'd4, v); chk("R8 both full", v, fstat(DEPTH, DEPTH));
        rd(3'd3, v); chk("R7 overruns", {30'b0, v[5], v[3]}, 32'h3);
        tx_take(b); chk("R8 tx head kept", {24'b0, b}, 32'h0);

        // R11 / R10
        xfer_event = 1'b1; @(negedge clk); xfer_event = 1'b0;
        rd(3'd3, v); chk("R11 xfer event", {31'b0, v[9]}, 32'h1);
        wr(3'd3, 32'h0000_0204);
        rd(3'd3, v); chk("R10 selective clear", {22'b0, v[9:2]}, 32'b0000_1110);

        // R12 enables
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R12 enable mask", v, 32'h243);
        wr(3'd2, 32'h0); idle(1);
        chk("R12 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h2); idle(1);
        chk("R12 irq rx high", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h40); idle(1);
        chk("R12 irq trail only", {31'b0, irq}, 32'h0);

        // R5: disabled queues ignore everything
        wr(3'd0, 32'h0);
        idle(1);
        wr(3'd3, 32'h3FF);
        rx_give(8'h55); rd(3'd6, v); tx_take(b); wr(3'd5, 32'h66);
        idle(2);
        rd(3'd4, v); chk("R5 disabled status", v, fstat(0, 0));
        rd(3'd3, v); chk("R5 no pending", v, 32'h0);

        // R9 trailing
        wr(3'd0, ctrl_word(1, 1, 4, 0));
        wr(3'd1, 32'h3);
        rx_give(8'h77); rx_give(8'h78);
        wr(3'd3, 32'h3FF);
        tick_once(); tick_once();
        rd(3'd3, v); chk("R9 not yet", {31'b0, v[6]}, 32'h0);
        chk("R12 no trail irq", {31'b0, irq}, 32'h0);
        tick_once();
        rd(3'd3, v); chk("R9 fires on 3rd tick", {31'b0, v[6]}, 32'h1);
        chk("R12 trail irq", {31'b0, irq}, 32'h1);
        wr(3'd3, 32'h40);
        tick_once(); tick_once(); tick_once(); tick_once();
        rd(3'd3, v); chk("R9 fires once", {31'b0, v[6]}, 32'h0);
        rd(3'd6, v); chk("R3 trail byte", v, 32'h77);
        tick_once(); tick_once();
        rd(3'd3, v); chk("R9 restart after read", {31'b0, v[6]}, 32'h0);
        tick_once();
        rd(3'd3, v); chk("R9 refire", {31'b0, v[6]}, 32'h1);
        rd(3'd6, v);
        wr(3'd2, 32'h0);

        // Random mix: R2 R3 R7 R8
        wr(3'd0, ctrl_word(1, 1, 0, 0));
        idle(1);
        wr(3'd3, 32'h3FF);
        e_txu = 0; e_txo = 0; e_rxu = 0; e_rxo = 0;
        for (int i = 0; i < 800; i++) begin
            int op;
            op = $urandom % 10;
            b  = 8'($urandom);
            if (op < 3) begin
                wr(3'd5, {24'b0, b});
                if (txq.size() == DEPTH) e_txo = 1; else txq.push_back(b);
            end else if (op < 5) begin
                tx_take(b);
                if (txq.size() == 0) e_txu = 1;
                else chk("R2 random tx", {24'b0, b}, {24'b0, txq.pop_front()});
            end else if (op < 8) begin
                rx_give(b);
                if (rxq.size() == DEPTH) e_rxo = 1; else rxq.push_back(b);
            end else begin
                rd(3'd6, v);
                if (rxq.size() == 0) begin
                    e_rxu = 1;
                    chk("R3 random empty", v, 32'h0);
                end else chk("R3 random rx", v, {24'b0, rxq.pop_front()});
            end
        end
        rd(3'd4, v); chk("R8 random levels", v, fstat(txq.size(), rxq.size()));
        rd(3'd3, v); chk("R7 random errors", {28'b0, v[5:2]}, {28'b0, e_rxo, e_rxu, e_txo, e_txu});

        finish_run();
    end

endmodule